// File: doc/BRIEF.md
# Chained Input Expander Controller

This block reads a daisy chain of parallel-in, serial-out shift registers so that three pins (a serial clock, a parallel-load strobe and a serial data input) can sample up to eight bytes of external inputs. A read request carries a byte count N. The block first strobes the load pin so that every register captures its parallel inputs at once. It then clocks N bytes in serially and presents them on a wide result bus. The register nearest the controller supplies the first byte.

Every level on the clock and load pins is held for a parameterised number of system clock cycles, which slows the serial side for long or heavily loaded wiring. Each of the clock, load and data pins has its own polarity parameter. The load and clock pins may be wired in common with an output chain controller. When both are shared, the block starts a read only after the output side has reported a completed shift sequence. This keeps the shared pins in the order that the input registers need.

Top module: `serin_chain_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until a read starts, `busy_o` and `done_o` are low, `data_o` is all zero, and `ser_clk_o` and `ser_load_o` sit at their inactive levels.
- R2: A `start_i` pulse seen while idle is accepted, and `busy_o` is high from the following cycle. A `start_i` seen while a read is running is ignored and changes neither that read's length nor its data.
- R3: Each read begins with the load pin active for EDGE_WAIT cycles, then inactive for EDGE_WAIT cycles, before the first active clock level. The clock pin is never active while the load pin is active.
- R4: A read of N bytes shifts 8·N bits. Each bit has the clock inactive for EDGE_WAIT cycles and then active for EDGE_WAIT cycles, and the data pin is sampled in the last inactive cycle, just before the active edge. `done_o` rises exactly 2·EDGE_WAIT + 16·N·EDGE_WAIT cycles after the clock edge that accepted the start.
- R5: Byte k (k = 1..N) of the result lies in `data_o[8k-1:8k-8]`. Byte 1 comes from the register nearest the controller. Within each byte the first bit received becomes bit 7.
- R6: Result bytes above N read as zero.
- R7: A count of 0 is treated as 1, and a count above MAX_BYTES (default 8) is treated as MAX_BYTES.
- R8: `done_o` is a one-cycle pulse. `data_o` takes the new result in the same cycle and holds it unchanged until the next `done_o`.
- R9: CLK_ACT_HIGH and LOAD_ACT_HIGH select the active level of each pin (1 = high active). DATA_INVERT = 1 means a low data pin reads as a 1 bit.
- R10: With SHARE_BOTH = 1, a pulse on `out_done_i` arms one read. A start is accepted only while armed, and acceptance disarms. With SHARE_BOTH = 0, `out_done_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Read request, one cycle |
| count_i | input | CW (4) | Bytes to read, 1..MAX_BYTES |
| out_done_i | input | 1 | Pulse from the output chain when its shift sequence is finished |
| ser_data_i | input | 1 | Serial data from the nearest register |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| data_o | output | 8·MAX_BYTES (64) | Result bytes, byte 1 in bits 7:0 |
| ser_clk_o | output | 1 | Shift clock to the chain |
| ser_load_o | output | 1 | Parallel load strobe to the chain |

## Verification
`busy_o` is checked one cycle after the accepting edge. `done_o` is due exactly 2·W + 16·N·W edges after that edge. For the default W = 2 this is 36 cycles for one byte and 260 cycles for eight. The bench counts edges from acceptance and compares the count where `done_o` is first seen, and it also checks `data_o` in that same cycle. All outputs are sampled on the falling clock edge. A port monitor counts load-active cycles before the first active clock level. Hold and ignore checks come after several more edges, with the pattern at the chain inputs changed in between.

// File: rtl/serin_pkg.sv
package serin_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_GAP,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/serin_pace.sv
// Phase timer: counts cycles spent in the current pin level.
module serin_pace #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic adv_i,
  output logic last_o
);
  localparam int TW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_i || adv_i) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == TW'(HOLD - 1));
endmodule

// File: rtl/serin_gather.sv
// Collects sampled bits into byte slots and holds the committed result.
module serin_gather #(
  parameter int unsigned MAX_BYTES = 8,
  localparam int DW = 8 * MAX_BYTES,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          sample_i,
  input  logic          commit_i,
  input  logic [BW-1:0] bit_idx_i,
  input  logic          bit_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] work_q, work_d;
  logic [DW-1:0] res_q;
  logic [BW-1:0] pos;

  // first bit of each byte lands in bit 7 of that byte
  assign pos = bit_idx_i ^ BW'(7);

  always_comb begin
    work_d = work_q;
    if (clear_i)       work_d = '0;
    else if (sample_i) work_d[pos] = bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) work_q <= '0;
    else        work_q <= work_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (commit_i) res_q <= work_q;
  end

  assign data_o = res_q;
endmodule

// File: rtl/serin_seq.sv
// Read sequencer: load strobe, gap, then clock low/high per bit.
module serin_seq
  import serin_pkg::*;
#(
  parameter int unsigned MAX_BYTES     = 8,
  parameter bit          CLK_ACT_HIGH  = 1'b1,
  parameter bit          LOAD_ACT_HIGH = 1'b1,
  localparam int CW = $clog2(MAX_BYTES + 1),
  localparam int BW = $clog2(8 * MAX_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          go_ok_i,
  input  logic [CW-1:0] count_i,
  input  logic          last_i,
  output logic          run_o,
  output logic          adv_o,
  output logic          sample_o,
  output logic          clear_o,
  output logic          commit_o,
  output logic [BW-1:0] bit_idx_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ser_clk_o,
  output logic          ser_load_o
);
  localparam logic CK_ON = CLK_ACT_HIGH;
  localparam logic LD_ON = LOAD_ACT_HIGH;

  seq_state_e    state_q, state_d;
  logic [BW-1:0] bit_q, bit_d, top_q, top_d, top_new;
  logic          ck_q, ck_d, ld_q, ld_d;
  int unsigned   n_sel;

  always_comb begin
    if (count_i == '0)                  n_sel = 1;
    else if (count_i > CW'(MAX_BYTES))  n_sel = MAX_BYTES;
    else                                n_sel = int'(count_i);
    top_new = BW'(n_sel * 8 - 1);
  end

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    top_d    = top_q;
    adv_o    = 1'b0;
    sample_o = 1'b0;
    clear_o  = 1'b0;
    commit_o = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i && go_ok_i) begin
        state_d = ST_LOAD;
        clear_o = 1'b1;
        bit_d   = '0;
        top_d   = top_new;
      end
      ST_LOAD: if (last_i) begin
        adv_o   = 1'b1;
        state_d = ST_GAP;
      end
      ST_GAP: if (last_i) begin
        adv_o   = 1'b1;
        state_d = ST_LOW;
      end
      ST_LOW: if (last_i) begin
        adv_o    = 1'b1;
        sample_o = 1'b1;
        state_d  = ST_HIGH;
      end
      ST_HIGH: if (last_i) begin
        adv_o = 1'b1;
        if (bit_q == top_q) begin
          state_d  = ST_DONE;
          commit_o = 1'b1;
        end else begin
          bit_d   = bit_q + 1'b1;
          state_d = ST_LOW;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    ck_d = (state_d == ST_HIGH) ? CK_ON : ~CK_ON;
    ld_d = (state_d == ST_LOAD) ? LD_ON : ~LD_ON;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      top_q   <= '0;
      ck_q    <= ~CK_ON;
      ld_q    <= ~LD_ON;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      top_q   <= top_d;
      ck_q    <= ck_d;
      ld_q    <= ld_d;
    end
  end

  assign run_o      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign busy_o     = run_o;
  assign done_o     = (state_q == ST_DONE);
  assign bit_idx_o  = bit_q;
  assign ser_clk_o  = ck_q;
  assign ser_load_o = ld_q;
endmodule

// File: rtl/serin_chain_ctrl.sv
module serin_chain_ctrl #(
  parameter int unsigned MAX_BYTES     = 8,
  parameter int unsigned EDGE_WAIT     = 2,
  parameter bit          CLK_ACT_HIGH  = 1'b1,
  parameter bit          LOAD_ACT_HIGH = 1'b1,
  parameter bit          DATA_INVERT   = 1'b0,
  parameter bit          SHARE_BOTH    = 1'b0,
  localparam int CW = $clog2(MAX_BYTES + 1),
  localparam int DW = 8 * MAX_BYTES,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          out_done_i,
  input  logic          ser_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          ser_clk_o,
  output logic          ser_load_o
);
  logic          rst_meta, rst_core;
  logic          run, adv, last, sample, clear, commit;
  logic [BW-1:0] bit_idx;
  logic          go_ok, tok_pend, tok_d, bit_in;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  generate
    if (SHARE_BOTH) begin : g_token
      logic tok_q;
      assign tok_d = (tok_q & ~clear) | out_done_i;
      always_ff @(posedge clk or negedge rst_core) begin
        if (!rst_core) tok_q <= 1'b0;
        else           tok_q <= tok_d;
      end
      assign tok_pend = tok_q;
      assign go_ok    = tok_q;
    end else begin : g_free
      assign tok_d    = 1'b0;
      assign tok_pend = 1'b0;
      assign go_ok    = 1'b1;
    end
  endgenerate

  assign bit_in = ser_data_i ^ DATA_INVERT;

  serin_pace #(.HOLD(EDGE_WAIT)) u_pace (
    .clk(clk), .rst_n(rst_core), .run_i(run), .adv_i(adv), .last_o(last)
  );

  serin_seq #(
    .MAX_BYTES(MAX_BYTES), .CLK_ACT_HIGH(CLK_ACT_HIGH), .LOAD_ACT_HIGH(LOAD_ACT_HIGH)
  ) u_seq (
    .clk(clk), .rst_n(rst_core), .start_i(start_i), .go_ok_i(go_ok),
    .count_i(count_i), .last_i(last), .run_o(run), .adv_o(adv),
    .sample_o(sample), .clear_o(clear), .commit_o(commit), .bit_idx_o(bit_idx),
    .busy_o(busy_o), .done_o(done_o), .ser_clk_o(ser_clk_o), .ser_load_o(ser_load_o)
  );

  serin_gather #(.MAX_BYTES(MAX_BYTES)) u_gather (
    .clk(clk), .rst_n(rst_core), .clear_i(clear), .sample_i(sample),
    .commit_i(commit), .bit_idx_i(bit_idx), .bit_i(bit_in), .data_o(data_o)
  );
endmodule

// File: rtl/serin_chain_ctrl_chk.sv
module serin_chain_ctrl_chk #(
  parameter bit CLK_ACT_HIGH  = 1'b1,
  parameter bit LOAD_ACT_HIGH = 1'b1,
  parameter bit SHARE_BOTH    = 1'b0,
  parameter int DW            = 64
) (
  input logic          clk,
  input logic          rst_core,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] data_o,
  input logic          ser_clk_o,
  input logic          ser_load_o,
  input logic          tok_pend
);
  logic ck_act, ld_act;
  assign ck_act = (ser_clk_o == CLK_ACT_HIGH);
  assign ld_act = (ser_load_o == LOAD_ACT_HIGH);

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_core)
    !busy_o |-> (!ck_act && !ld_act)); // R1

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_core)
    (start_i && !busy_o && !done_o && (!SHARE_BOTH || tok_pend)) |=> busy_o); // R2

  AST_NO_CLK_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_core)
    !(ck_act && ld_act)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_core)
    done_o |=> !done_o); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_core)
    !done_o |-> $stable(data_o)); // R8

  AST_TOKEN_GATE: assert property (@(posedge clk) disable iff (!rst_core)
    $rose(busy_o) |-> (!SHARE_BOTH || $past(tok_pend))); // R10
endmodule

bind serin_chain_ctrl serin_chain_ctrl_chk #(
  .CLK_ACT_HIGH(CLK_ACT_HIGH), .LOAD_ACT_HIGH(LOAD_ACT_HIGH),
  .SHARE_BOTH(SHARE_BOTH), .DW(DW)
) u_chk (
  .clk(clk), .rst_core(rst_core), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .data_o(data_o), .ser_clk_o(ser_clk_o),
  .ser_load_o(ser_load_o), .tok_pend(tok_pend)
);

// File: tb/chain_model.sv
// Behavioural chain of parallel-in serial-out registers, register 0 nearest.
module chain_model #(
  parameter int NREG          = 8,
  parameter bit CLK_ACT_HIGH  = 1'b1,
  parameter bit LOAD_ACT_HIGH = 1'b1,
  parameter bit DATA_INVERT   = 1'b0
) (
  input  logic              clk,
  input  logic              ck_pin,
  input  logic              ld_pin,
  input  logic [8*NREG-1:0] par_i,
  output logic              sd_o
);
  logic [8*NREG-1:0] sr;
  logic              ck_prev;

  function automatic logic [8*NREG-1:0] shifted(input logic [8*NREG-1:0] v);
    logic [8*NREG-1:0] r;
    for (int k = 0; k < NREG; k++) begin
      r[8*k+1 +: 7] = v[8*k +: 7];
      r[8*k]        = (k == NREG - 1) ? 1'b0 : v[8*(k+1)+7];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    ck_prev <= ck_pin;
    if (ld_pin == LOAD_ACT_HIGH) sr <= par_i;
    else if (ck_pin == CLK_ACT_HIGH && ck_prev != CLK_ACT_HIGH) sr <= shifted(sr);
  end

  assign sd_o = sr[7] ^ DATA_INVERT;
endmodule

// File: tb/test_serin_chain_ctrl.sv
module test_serin_chain_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;

  // instance A: default parameters, EDGE_WAIT = 2
  logic        a_start, a_odone, a_busy, a_done, a_sck, a_sld, a_sd;
  logic [3:0]  a_cnt;
  logic [63:0] a_data, a_par;
  // instance B: inverted pins, EDGE_WAIT = 1, both pins shared
  logic        b_start, b_odone, b_busy, b_done, b_sck, b_sld, b_sd;
  logic [3:0]  b_cnt;
  logic [63:0] b_data, b_par;

  serin_chain_ctrl i_serin_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(a_start), .count_i(a_cnt), .out_done_i(a_odone),
    .ser_data_i(a_sd), .busy_o(a_busy), .done_o(a_done), .data_o(a_data),
    .ser_clk_o(a_sck), .ser_load_o(a_sld)
  );
  chain_model u_model_a (.clk(clk), .ck_pin(a_sck), .ld_pin(a_sld), .par_i(a_par), .sd_o(a_sd));

  serin_chain_ctrl #(
    .EDGE_WAIT(1), .CLK_ACT_HIGH(1'b0), .LOAD_ACT_HIGH(1'b0), .DATA_INVERT(1'b1), .SHARE_BOTH(1'b1)
  ) i_serin_chain_ctrl_shared (
    .clk(clk), .rst_n(rst_n), .start_i(b_start), .count_i(b_cnt), .out_done_i(b_odone),
    .ser_data_i(b_sd), .busy_o(b_busy), .done_o(b_done), .data_o(b_data),
    .ser_clk_o(b_sck), .ser_load_o(b_sld)
  );
  chain_model #(.CLK_ACT_HIGH(1'b0), .LOAD_ACT_HIGH(1'b0), .DATA_INVERT(1'b1)) u_model_b (
    .clk(clk), .ck_pin(b_sck), .ld_pin(b_sld), .par_i(b_par), .sd_o(b_sd)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // port monitor on A for the load-before-clock ordering (R3)
  int ld_cycles;
  bit seen_ld, order_bad;
  always @(negedge clk) begin
    if (a_sld) begin
      ld_cycles++;
      seen_ld = 1'b1;
    end
    if (a_sck && (!seen_ld || a_sld)) order_bad = 1'b1;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] low_bytes(input logic [63:0] v, input int n);
    logic [63:0] m;
    m = (n >= 8) ? '1 : ((64'd1 << (8 * n)) - 64'd1);
    return v & m;
  endfunction

  task automatic read_a(input logic [3:0] cnt, output int cyc, output logic busy1);
    @(negedge clk); a_start = 1'b1; a_cnt = cnt;
    ld_cycles = 0; seen_ld = 1'b0; order_bad = 1'b0;
    @(negedge clk); a_start = 1'b0;
    busy1 = a_busy;
    cyc = 0;
    while (!a_done && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_reset();
    chk("R1", "busy A", 64'(a_busy), 64'd0);
    chk("R1", "done A", 64'(a_done), 64'd0);
    chk("R1", "data A", a_data, 64'd0);
    chk("R1", "pins A", {62'd0, a_sck, a_sld}, 64'd0);
    chk("R1", "pins B inactive high", {62'd0, b_sck, b_sld}, 64'd3);
    chk("R1", "data B", b_data, 64'd0);
  endtask

  task automatic t_single();
    int cyc; logic b1;
    a_par = 64'h1122_3344_5566_77A5;
    read_a(4'd1, cyc, b1);
    chk("R2", "busy after start", 64'(b1), 64'd1);
    chk("R4", "cycles N=1", 64'(cyc), 64'd36);
    chk("R5", "byte1 nearest", a_data, 64'hA5);
    chk("R6", "upper bytes zero", a_data >> 8, 64'd0);
    @(negedge clk);
    chk("R8", "done one cycle", 64'(a_done), 64'd0);
  endtask

  task automatic t_full();
    int cyc; logic b1;
    a_par = 64'h8001_7E3C_C35A_0FF0;
    read_a(4'd8, cyc, b1);
    chk("R4", "cycles N=8", 64'(cyc), 64'd260);
    chk("R5", "eight bytes in order", a_data, a_par);
    chk("R3", "load active cycles", 64'(ld_cycles), 64'd2);
    chk("R3", "clock only after load", 64'(order_bad), 64'd0);
  endtask

  task automatic t_partial_hold();
    int cyc; logic b1; logic [63:0] got;
    a_par = 64'hDEAD_BEEF_0BAD_F00D;
    read_a(4'd3, cyc, b1);
    chk("R4", "cycles N=3", 64'(cyc), 64'd100);
    chk("R6", "three bytes then zero", a_data, low_bytes(a_par, 3));
    got = a_data;
    a_par = 64'h0123_4567_89AB_CDEF;
    repeat (20) @(negedge clk);
    chk("R8", "result held", a_data, got);
  endtask

  task automatic t_ignore_busy();
    int cyc; logic b1;
    a_par = 64'h5555_AAAA_3333_C1C2;
    fork
      read_a(4'd2, cyc, b1);
      begin
        repeat (10) @(negedge clk);
        a_start = 1'b1; a_cnt = 4'd8;
        @(negedge clk); a_start = 1'b0;
      end
    join
    chk("R2", "length unchanged", 64'(cyc), 64'd68);
    chk("R2", "data of first request", a_data, low_bytes(a_par, 2));
    repeat (3) @(negedge clk);
    chk("R2", "no second read", 64'(a_busy), 64'd0);
  endtask

  task automatic t_clamp();
    int cyc; logic b1;
    a_par = 64'h0F1E_2D3C_4B5A_6978;
    read_a(4'd0, cyc, b1);
    chk("R7", "count 0 cycles", 64'(cyc), 64'd36);
    chk("R7", "count 0 data", a_data, 64'h78);
    read_a(4'd12, cyc, b1);
    chk("R7", "count 12 cycles", 64'(cyc), 64'd260);
    chk("R7", "count 12 data", a_data, a_par);
  endtask

  task automatic t_shared();
    int cyc;
    b_par = 64'h9876_5432_C0DE_81E7;
    @(negedge clk); b_start = 1'b1; b_cnt = 4'd4;
    @(negedge clk); b_start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10", "no read without token", {62'd0, b_busy, b_done}, 64'd0);
    b_odone = 1'b1;
    @(negedge clk); b_odone = 1'b0; b_start = 1'b1;
    @(negedge clk); b_start = 1'b0;
    chk("R10", "busy after token", 64'(b_busy), 64'd1);
    cyc = 0;
    while (!b_done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk("R4", "cycles W=1 N=4", 64'(cyc), 64'd66);
    chk("R9", "inverted pins data", b_data, low_bytes(b_par, 4));
    @(negedge clk); b_start = 1'b1; b_cnt = 4'd1;
    @(negedge clk); b_start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10", "token consumed", 64'(b_busy), 64'd0);
    chk("R9", "idle pins high", {62'd0, b_sck, b_sld}, 64'd3);
  endtask

  task automatic t_token_ignored_a();
    int cyc; logic b1;
    a_odone = 1'b1;
    @(negedge clk); a_odone = 1'b0;
    a_par = 64'h0000_0000_0000_0042;
    read_a(4'd1, cyc, b1);
    chk("R10", "no sharing: token irrelevant", a_data, 64'h42);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_start = 1'b0; a_cnt = 4'd1; a_odone = 1'b0; a_par = '0;
    b_start = 1'b0; b_cnt = 4'd1; b_odone = 1'b0; b_par = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_full();
    t_partial_hold();
    t_ignore_busy();
    t_clamp();
    t_shared();
    t_token_ignored_a();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule